// File: doc/BRIEF.md
# PLL Relock Configuration Sequencer

This block changes the multiplier, pre-divider and post-divider of a PLL without ever handing the PLL new ratios while it is running locked. A single start request carries the target values. The sequencer then steps through a fixed order. It puts the PLL into bypass and waits until the PLL reports bypass. It loads the multiplier and pre-divider, loads the post-divider one cycle later, and then requests lock. Finally it waits until the PLL reports lock. A one-cycle done pulse marks success.

Both status flags from the PLL come from another clock domain, so each one passes through a two-flop synchronizer before the sequencer acts on it. Each of the two waits is limited by a cycle budget supplied on an input. If a wait runs past that budget, the sequencer gives up, leaves the PLL in bypass, raises a timeout flag and returns to idle. A start request that arrives while a sequence is running has no effect.

Top module: `pll_relock_seq`

## Requirements
- R1: While reset is held and just after it is released, the mode output is the lock code 3'h7. Busy, done and timeout are 0, and the multiplier, pre-divider and post-divider outputs are 0.
- R2: A start request accepted in idle changes the mode output to the bypass code 3'h4 and raises busy on the next clock edge. Timeout is cleared at the same edge.
- R3: The multiplier and pre-divider outputs change only while the mode output is 3'h4. They are written only after the synchronized bypass status reads 1 and the synchronized lock status reads 0.
- R4: The post-divider output is written exactly one cycle after the multiplier and pre-divider, while the mode is still 3'h4.
- R5: The mode output changes to 3'h7 exactly one cycle after the post-divider is written. The sequence completes only when the synchronized lock status reads 1 and the synchronized bypass status reads 0.
- R6: On success, done is high for exactly one cycle. Busy falls in that same cycle, and the mode output is 3'h7.
- R7: If a wait state sees its condition unmet for more than tmo_limit_i cycles, timeout rises. The rise comes tmo_limit_i+1 cycles after the wait began. At the same time busy falls and the mode output is left at 3'h4. Timeout then stays high until the next accepted start.
- R8: A start request while busy is ignored. The values applied at the end are the ones captured at the accepted start.
- R9: Both status inputs are synchronized by two flops. The multiplier is written exactly three cycles after the bypass status rises, and done rises exactly three cycles after the lock status rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a reprogramming sequence |
| mult_i | input | MULT_W | Target multiplier |
| div_i | input | DIV_W | Target pre-divider |
| post_i | input | POST_W | Target post-divider |
| tmo_limit_i | input | TMO_W | Cycle budget for each wait state |
| byp_stat_i | input | 1 | PLL reports bypass (asynchronous) |
| lock_stat_i | input | 1 | PLL reports lock (asynchronous) |
| pll_mode_o | output | 3 | Mode request to the PLL: 3'h4 bypass, 3'h7 lock |
| pll_mult_o | output | MULT_W | Multiplier applied to the PLL |
| pll_div_o | output | DIV_W | Pre-divider applied to the PLL |
| pll_post_o | output | POST_W | Post-divider applied to the PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful lock |
| timeout_o | output | 1 | A wait exceeded its budget; held until next start |

## Verification
The assertions check several rules on every cycle. The ratio outputs may change only under the bypass code. The post-divider must follow with the multiplier already stable. Lock is requested only from a busy sequence, and done lasts a single cycle. A timeout leaves the mode in bypass and stays raised while idle. Other behaviour can only be shown by the bench's scenarios against a responding PLL model. These are the exact three-cycle synchronizer latency on both status flags and the precise timeout instant in each wait state. They also include that a start issued mid-sequence leaves the captured targets untouched.

// File: rtl/pll_relock_seq.sv
module pll_relock_seq #(
  parameter int MULT_W = 11,
  parameter int DIV_W  = 7,
  parameter int POST_W = 5,
  parameter int TMO_W  = 16,
  parameter logic [2:0] MODE_BYP  = 3'h4,
  parameter logic [2:0] MODE_LOCK = 3'h7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [POST_W-1:0] post_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              byp_stat_i,
  input  logic              lock_stat_i,
  output logic [2:0]        pll_mode_o,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic [POST_W-1:0] pll_post_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_WBYP, S_POST, S_LREQ, S_WLOCK
  } st_t;

  st_t               st;
  logic [1:0]        byp_sy, lock_sy;
  logic [MULT_W-1:0] t_mult;
  logic [DIV_W-1:0]  t_div;
  logic [POST_W-1:0] t_post;
  logic [TMO_W-1:0]  cnt;

  wire byp_ok  = byp_sy[1] & ~lock_sy[1];
  wire lock_ok = lock_sy[1] & ~byp_sy[1];
  wire expired = cnt >= tmo_limit_i;

  assign busy_o = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_sy  <= '0;
      lock_sy <= '0;
    end else begin
      byp_sy  <= {byp_sy[0], byp_stat_i};
      lock_sy <= {lock_sy[0], lock_stat_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pll_mode_o <= MODE_LOCK;
      pll_mult_o <= '0;
      pll_div_o  <= '0;
      pll_post_o <= '0;
      t_mult     <= '0;
      t_div      <= '0;
      t_post     <= '0;
      cnt        <= '0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          t_mult     <= mult_i;
          t_div      <= div_i;
          t_post     <= post_i;
          pll_mode_o <= MODE_BYP;
          timeout_o  <= 1'b0;
          cnt        <= '0;
          st         <= S_WBYP;
        end
        S_WBYP: begin
          if (byp_ok) begin
            pll_mult_o <= t_mult;
            pll_div_o  <= t_div;
            st         <= S_POST;
          end else if (expired) begin
            timeout_o <= 1'b1;
            st        <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_POST: begin
          pll_post_o <= t_post;
          st         <= S_LREQ;
        end
        S_LREQ: begin
          pll_mode_o <= MODE_LOCK;
          cnt        <= '0;
          st         <= S_WLOCK;
        end
        S_WLOCK: begin
          if (lock_ok) begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else if (expired) begin
            timeout_o  <= 1'b1;
            pll_mode_o <= MODE_BYP;
            st         <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_relock_seq_chk.sv
module pll_relock_seq_chk #(
  parameter int MULT_W = 11,
  parameter int DIV_W  = 7,
  parameter int POST_W = 5,
  parameter logic [2:0] MODE_BYP  = 3'h4,
  parameter logic [2:0] MODE_LOCK = 3'h7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        pll_mode_o,
  input logic [MULT_W-1:0] pll_mult_o,
  input logic [DIV_W-1:0]  pll_div_o,
  input logic [POST_W-1:0] pll_post_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o
);

  assert_ratio_in_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pll_mult_o) || !$stable(pll_div_o)) |-> (pll_mode_o == MODE_BYP && busy_o));

  assert_post_after_ratio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_post_o) |-> (pll_mode_o == MODE_BYP && busy_o && $stable(pll_mult_o)));

  assert_lock_req_from_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mode_o == MODE_LOCK && $past(pll_mode_o) != MODE_LOCK) |-> ($past(busy_o) && $stable(pll_post_o)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && pll_mode_o == MODE_LOCK && !timeout_o));

  assert_tmo_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (pll_mode_o == MODE_BYP && !busy_o));

  assert_tmo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !busy_o) |=> (timeout_o || busy_o));

endmodule

bind pll_relock_seq pll_relock_seq_chk #(
  .MULT_W(MULT_W), .DIV_W(DIV_W), .POST_W(POST_W),
  .MODE_BYP(MODE_BYP), .MODE_LOCK(MODE_LOCK)
) chk_i (.*);

// File: tb/pll_relock_seq_tb_top.sv
module pll_relock_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 11, DW = 7, PW = 5, TW = 16;

  typedef struct packed {
    logic [MW-1:0] m;
    logic [DW-1:0] d;
    logic [PW-1:0] p;
    logic [7:0]    bd;
    logic [7:0]    ld;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{11'd532,  7'd23, 5'd1, 8'd2, 8'd4},
    '{11'd400,  7'd11, 5'd2, 8'd0, 8'd0},
    '{11'd1000, 7'd50, 5'd3, 8'd7, 8'd1},
    '{11'd75,   7'd2,  5'd9, 8'd1, 8'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [MW-1:0] mult_in = '0;
  logic [DW-1:0] div_in = '0;
  logic [PW-1:0] post_in = '0;
  logic [TW-1:0] tmo_lim = 16'd200;
  logic byp_stat, lock_stat;
  logic [2:0] mode;
  logic [MW-1:0] mult_o;
  logic [DW-1:0] div_o;
  logic [PW-1:0] post_o;
  logic busy, done, tmo;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit byp_en = 1, lock_en = 1;
  int byp_dly = 0, lock_dly = 0;
  logic [2:0] mode_q;
  int rcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_relock_seq #(.MULT_W(MW), .DIV_W(DW), .POST_W(PW), .TMO_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .mult_i(mult_in), .div_i(div_in), .post_i(post_in), .tmo_limit_i(tmo_lim),
    .byp_stat_i(byp_stat), .lock_stat_i(lock_stat),
    .pll_mode_o(mode), .pll_mult_o(mult_o), .pll_div_o(div_o), .pll_post_o(post_o),
    .busy_o(busy), .done_o(done), .timeout_o(tmo));

  always @(posedge clk) begin
    if (!rst_n) begin
      byp_stat <= 1'b0; lock_stat <= 1'b1; mode_q <= 3'h7; rcnt <= 0;
    end else if (mode != mode_q) begin
      mode_q <= mode; rcnt <= 0;
    end else begin
      rcnt <= rcnt + 1;
      if (mode == 3'h4) begin
        lock_stat <= 1'b0;
        if (byp_en && rcnt >= byp_dly) byp_stat <= 1'b1;
      end else if (mode == 3'h7) begin
        if (lock_en && rcnt >= lock_dly) begin lock_stat <= 1'b1; byp_stat <= 1'b0; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 success, 1 timeout waiting bypass, 2 timeout waiting lock
  task automatic run_seq(input logic [MW-1:0] m, input logic [DW-1:0] d, input logic [PW-1:0] p,
                         input int bd, input int ld, input bit ben, input bit len,
                         input int lim, input bit inject, input int kind);
    int cyc, c_byp, c_lk, c_m, c_p, c_l, c_d, c_t, ndone;
    logic [MW-1:0] pm; logic [PW-1:0] pp; logic [2:0] pmode; logic pbyp, plock;
    logic [MW-1:0] m0;
    byp_dly = bd; lock_dly = ld; byp_en = ben; lock_en = len; tmo_lim = lim[TW-1:0];
    m0 = mult_o;
    mult_in = m; div_in = d; post_in = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk(mode == 3'h4 && busy, "R2", "mode/busy after start", int'(mode), 4);
    chk(!tmo, "R7", "timeout cleared by start", int'(tmo), 0);
    c_byp = -1; c_lk = -1; c_m = -1; c_p = -1; c_l = -1; c_d = -1; c_t = -1; ndone = 0;
    pm = mult_o; pp = post_o; pmode = mode; pbyp = byp_stat; plock = lock_stat;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 1) begin start = 1'b1; mult_in = ~m; end
      if (inject && cyc == 2) begin start = 1'b0; mult_in = m; end
      if (byp_stat && !pbyp && c_byp < 0) c_byp = cyc;
      if (lock_stat && !plock && c_lk < 0) c_lk = cyc;
      if (mult_o != pm && c_m < 0) c_m = cyc;
      if (post_o != pp && c_p < 0) c_p = cyc;
      if (mode == 3'h7 && pmode != 3'h7 && c_l < 0) c_l = cyc;
      if (done) begin ndone++; c_d = cyc; end
      if (tmo && c_t < 0) c_t = cyc;
      pm = mult_o; pp = post_o; pmode = mode; pbyp = byp_stat; plock = lock_stat;
      if (!busy) break;
    end
    chk(!busy, "R6", "sequence ended", int'(busy), 0);
    if (kind == 0) begin
      if (c_byp >= 0) chk(c_m == c_byp + 3, "R9", "ratio write after bypass rise", c_m - c_byp, 3);
      chk(c_p == c_m + 1, "R4", "post after ratio", c_p - c_m, 1);
      chk(c_l == c_p + 1, "R5", "lock request after post", c_l - c_p, 1);
      chk(c_d == c_lk + 3, "R9", "done after lock rise", c_d - c_lk, 3);
      chk(ndone == 1 && c_d == cyc, "R6", "single done at busy fall", ndone, 1);
      chk(mult_o == m, inject ? "R8" : "R3", "multiplier applied", int'(mult_o), int'(m));
      chk(div_o == d, "R3", "pre-divider applied", int'(div_o), int'(d));
      chk(post_o == p, "R4", "post-divider applied", int'(post_o), int'(p));
      chk(mode == 3'h7 && !tmo, "R5", "mode lock, no timeout", int'(mode), 7);
      @(negedge clk);
      chk(!done, "R6", "done lasts one cycle", int'(done), 0);
    end else begin
      if (kind == 1) begin
        chk(c_t == lim + 1, "R7", "bypass wait timeout cycle", c_t, lim + 1);
        chk(c_m < 0 && mult_o == m0, "R3", "ratio not written without bypass", int'(mult_o), int'(m0));
      end else begin
        chk(c_t == c_l + lim + 1, "R7", "lock wait timeout cycle", c_t - c_l, lim + 1);
      end
      chk(mode == 3'h4 && ndone == 0, "R7", "mode left in bypass", int'(mode), 4);
      repeat (3) @(negedge clk);
      chk(tmo && !busy, "R7", "timeout held while idle", int'(tmo), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    chk(mode == 3'h7 && !busy && !done && !tmo, "R1", "outputs during reset", int'(mode), 7);
    do_reset();
    chk(mode == 3'h7 && !busy && !done && !tmo, "R1", "control after reset", int'(mode), 7);
    chk(mult_o == 0 && div_o == 0 && post_o == 0, "R1", "ratios after reset", int'(mult_o), 0);

    foreach (VEC[k])
      run_seq(VEC[k].m, VEC[k].d, VEC[k].p, int'(VEC[k].bd), int'(VEC[k].ld), 1, 1, 200, 0, 0);

    do_reset();
    run_seq(11'd321, 7'd5, 5'd7, 0, 0, 0, 1, 20, 0, 1);

    do_reset();
    run_seq(11'd300, 7'd9, 5'd4, 1, 0, 1, 0, 15, 0, 2);
    run_seq(11'd600, 7'd20, 5'd6, 3, 2, 1, 1, 200, 1, 0);

    do_reset();
    run_seq(11'd777, 7'd33, 5'd12, 4, 3, 1, 1, 200, 1, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule